// File: doc/BRIEF.md
# Multi-Reader Token Reference Counter

This block tracks how many consumers still have to read each token buffer in a small table. It is meant for systems where processors synchronise through shared storage without a central schedule. A token with several destinations needs more than a single full/empty flag, so each table entry holds a small counter.

A producer presents a buffer index and the number of consumers that will read the token. The write is accepted only when that entry is empty, and the entry's counter is then loaded with the consumer count. A consumer presents a buffer index and may proceed only while the counter is above zero. Each accepted read lowers the counter by one. The last remaining consumer, which sees a count of exactly one, is also told that it may modify the data in place.

Because a counter can be kept for each array element, part of an array can be consumed before the whole array has been produced. Each request gets its grant or deny response on the following cycle.

Top module: `rc_semaphore_table`

## Requirements
- R1: After reset every entry holds count zero, so a read of any of the 16 entries is denied.
- R2: A write with a nonzero consumer count to an entry holding zero is granted, and the entry then holds that count.
- R3: A read is granted exactly when the entry's count is above zero, and a granted read lowers the count by one. A denied read leaves the count unchanged.
- R4: A write to an entry whose count is nonzero is denied and leaves the count unchanged.
- R5: `rd_modify` is 1 exactly when a read is granted against a count of exactly one, and is 0 in every other case.
- R6: A write that supplies a consumer count of zero is denied and changes no entry.
- R7: When a write and a read name the same entry in one cycle, the read is judged against the count held before that cycle, and the write is denied.
- R8: Each response valid bit is 1 in the cycle after a request on its side and 0 in the cycle after no request on that side. A grant bit is 0 whenever its valid bit is 0.
- R9: A write and a read that name different entries in one cycle are both judged and applied independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Producer request |
| wr_idx | input | 4 | Entry index for the producer |
| wr_cnt | input | 4 | Number of consumers of the new token |
| rd_req | input | 1 | Consumer request |
| rd_idx | input | 4 | Entry index for the consumer |
| wr_rsp_vld | output | 1 | Producer response valid, one cycle after request |
| wr_grant | output | 1 | Producer may write the buffer |
| rd_rsp_vld | output | 1 | Consumer response valid, one cycle after request |
| rd_grant | output | 1 | Consumer may read the buffer |
| rd_modify | output | 1 | Consumer was the last reader and may modify in place |

## Verification
The assertions assume that request and index inputs are known and steady across each rising edge while reset is released. They also assume that the table never receives a set and a decrement for the same entry in one cycle, which the conflict rule is expected to prevent. The stimulus changes inputs only on falling edges. It keeps indices within a few low entries during the random phase, so that same-entry collisions, refused overwrites and last-reader cases all occur often. Consumer counts range from zero upward, so that ignored writes are exercised as well.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int unsigned RCS_ENTRIES = 16;
    localparam int unsigned RCS_CNT_W   = 4;

    typedef struct packed {
        logic wr_vld;
        logic wr_ok;
        logic rd_vld;
        logic rd_ok;
        logic rd_mod;
    } rcs_rsp_t;
endpackage

// File: rtl/rcs_rules.sv
module rcs_rules #(
    parameter int unsigned IW = 4,
    parameter int unsigned CW = 4
) (
    input  logic          wr_req,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_cnt,
    input  logic [CW-1:0] wr_old,
    input  logic          rd_req,
    input  logic [IW-1:0] rd_idx,
    input  logic [CW-1:0] rd_old,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          rd_last
);
    logic same_entry;

    always_comb begin
        same_entry = wr_req && rd_req && (wr_idx == rd_idx);
        // read side judged on the count held before this cycle
        rd_ok      = rd_req && (rd_old != '0);
        rd_last    = rd_ok && (rd_old == CW'(1));
        // write accepted only into an empty entry, nonzero fan-out, no collision
        wr_ok      = wr_req && (wr_cnt != '0) && (wr_old == '0) && !same_entry;
    end
endmodule

// File: rtl/rcs_table.sv
module rcs_table #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [CW-1:0] set_val,
    input  logic          dec_en,
    input  logic [IW-1:0] dec_idx,
    input  logic [IW-1:0] look_a_idx,
    output logic [CW-1:0] look_a_cnt,
    input  logic [IW-1:0] look_b_idx,
    output logic [CW-1:0] look_b_cnt
);
    logic [CW-1:0] cnt_q [N];
    logic [CW-1:0] cnt_d [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic hit_set;
        logic hit_dec;
        assign hit_set  = set_en && (set_idx == IW'(g));
        assign hit_dec  = dec_en && (dec_idx == IW'(g));
        assign cnt_d[g] = hit_set ? set_val
                        : hit_dec ? (cnt_q[g] - CW'(1))
                        : cnt_q[g];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end
    end

    assign look_a_cnt = cnt_q[look_a_idx];
    assign look_b_cnt = cnt_q[look_b_idx];

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (cnt_q[dec_idx] != '0));
    p_set_only_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (cnt_q[set_idx] == '0));
    p_set_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (set_val != '0));
    p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && dec_en) |-> (set_idx != dec_idx));
    p_dec_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(set_en && set_idx == dec_idx)) |=>
        (cnt_q[$past(dec_idx)] == $past(cnt_q[dec_idx]) - CW'(1)));
endmodule

// File: rtl/rc_semaphore_table.sv
module rc_semaphore_table
    import rcs_pkg::*;
#(
    parameter int unsigned ENTRIES = RCS_ENTRIES,
    parameter int unsigned CNT_W   = RCS_CNT_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             wr_rsp_vld,
    output logic             wr_grant,
    output logic             rd_rsp_vld,
    output logic             rd_grant,
    output logic             rd_modify
);
    logic [CNT_W-1:0] wr_old;
    logic [CNT_W-1:0] rd_old;
    logic             wr_ok;
    logic             rd_ok;
    logic             rd_last;
    rcs_rsp_t         rsp_d;
    rcs_rsp_t         rsp_q;

    rcs_rules #(.IW(IDX_W), .CW(CNT_W)) u_rules (
        .wr_req  (wr_req),
        .wr_idx  (wr_idx),
        .wr_cnt  (wr_cnt),
        .wr_old  (wr_old),
        .rd_req  (rd_req),
        .rd_idx  (rd_idx),
        .rd_old  (rd_old),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .rd_last (rd_last)
    );

    rcs_table #(.N(ENTRIES), .CW(CNT_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (wr_ok),
        .set_idx    (wr_idx),
        .set_val    (wr_cnt),
        .dec_en     (rd_ok),
        .dec_idx    (rd_idx),
        .look_a_idx (wr_idx),
        .look_a_cnt (wr_old),
        .look_b_idx (rd_idx),
        .look_b_cnt (rd_old)
    );

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.wr_vld = wr_req;
        rsp_d.wr_ok  = wr_ok;
        rsp_d.rd_vld = rd_req;
        rsp_d.rd_ok  = rd_ok;
        rsp_d.rd_mod = rd_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign wr_rsp_vld = rsp_q.wr_vld;
    assign wr_grant   = rsp_q.wr_ok;
    assign rd_rsp_vld = rsp_q.rd_vld;
    assign rd_grant   = rsp_q.rd_ok;
    assign rd_modify  = rsp_q.rd_mod;

    p_rd_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_rsp_vld);
    p_rd_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_rsp_vld);
    p_wr_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_rsp_vld);
    p_grant_needs_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant |-> wr_rsp_vld) and (rd_grant |-> rd_rsp_vld));
    p_modify_with_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_modify |-> rd_grant);
    p_zero_fanout_denied_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_cnt == '0) |=> !wr_grant);
    p_collision_wr_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req && wr_idx == rd_idx) |=> !wr_grant);
endmodule

// File: tb/sim_rc_semaphore_table.sv
module sim_rc_semaphore_table;
    localparam int PERIOD = 10;
    localparam int N      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [3:0] wr_cnt = '0;
    logic       rd_req = 1'b0;
    logic [3:0] rd_idx = '0;
    logic       wr_rsp_vld, wr_grant, rd_rsp_vld, rd_grant, rd_modify;

    int total = 0;
    int bad   = 0;
    int exp_cnt [N];

    always #(PERIOD/2) clk = ~clk;

    rc_semaphore_table u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_cnt(wr_cnt),
        .rd_req(rd_req), .rd_idx(rd_idx),
        .wr_rsp_vld(wr_rsp_vld), .wr_grant(wr_grant),
        .rd_rsp_vld(rd_rsp_vld), .rd_grant(rd_grant), .rd_modify(rd_modify)
    );

    // expected response bits: wr_vld, wr_ok, rd_vld, rd_ok, rd_mod
    function automatic logic [4:0] predict(input logic w, input int wi, input int wc,
                                           input logic r, input int ri, input int cur_w,
                                           input int cur_r);
        logic wok, rok, rmod;
        rok  = r && (cur_r != 0);
        rmod = rok && (cur_r == 1);
        wok  = w && (wc != 0) && (cur_w == 0) && !(r && ri == wi);
        return {w, wok, r, rok, rmod};
    endfunction

    task automatic step(input logic w, input int wi, input int wc,
                        input logic r, input int ri, input string tag);
        logic [4:0] exp_v, act_v;
        wr_req = w; wr_idx = 4'(wi); wr_cnt = 4'(wc);
        rd_req = r; rd_idx = 4'(ri);
        exp_v = predict(w, wi, wc, r, ri, exp_cnt[wi], exp_cnt[ri]);
        if (exp_v[1]) exp_cnt[ri] = exp_cnt[ri] - 1;
        if (exp_v[3]) exp_cnt[wi] = wc;
        @(posedge clk);
        @(negedge clk);
        act_v = {wr_rsp_vld, wr_grant, rd_rsp_vld, rd_grant, rd_modify};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s: rsp {wv,wg,rv,rg,mod} actual=%b expected=%b (w=%0d idx %0d cnt %0d, r=%0d idx %0d)",
                     tag, act_v, exp_v, w, wi, wc, r, ri);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed1);
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state: no responses pending
        total++;
        if ({wr_rsp_vld, wr_grant, rd_rsp_vld, rd_grant, rd_modify} !== 5'b0) begin
            bad++;
            $display("FAIL R8 reset: actual=%b expected=00000",
                     {wr_rsp_vld, wr_grant, rd_rsp_vld, rd_grant, rd_modify});
        end
        // R1 every entry empty after reset
        for (int i = 0; i < N; i++) step(1'b0, 0, 0, 1'b1, i, "R1");

        // R2 / R3 / R5 two-reader token
        step(1'b1, 5, 2, 1'b0, 0, "R2");
        step(1'b0, 0, 0, 1'b1, 5, "R3");
        step(1'b0, 0, 0, 1'b1, 5, "R5");
        step(1'b0, 0, 0, 1'b1, 5, "R3");
        // R6 zero fan-out write is ignored; read still denied
        step(1'b1, 5, 0, 1'b0, 0, "R6");
        step(1'b0, 0, 0, 1'b1, 5, "R6");
        // R4 overwrite refused; remaining count still 3 -> 2 without modify
        step(1'b1, 6, 3, 1'b0, 0, "R2");
        step(1'b1, 6, 1, 1'b0, 0, "R4");
        step(1'b0, 0, 0, 1'b1, 6, "R4");
        // R7 same-entry collision: read on old count (2), write denied
        step(1'b1, 6, 5, 1'b1, 6, "R7");
        step(1'b0, 0, 0, 1'b1, 6, "R7");
        step(1'b0, 0, 0, 1'b1, 6, "R7");
        // R7 collision on an empty entry: read denied, write denied
        step(1'b1, 6, 4, 1'b1, 6, "R7");
        // R9 different entries in one cycle
        step(1'b1, 3, 1, 1'b0, 0, "R2");
        step(1'b1, 4, 15, 1'b1, 3, "R9");
        step(1'b0, 0, 0, 1'b1, 4, "R9");
        // R8 idle cycle gives no response
        step(1'b0, 0, 0, 1'b0, 0, "R8");

        // random phase on a few entries to provoke collisions
        for (int k = 0; k < 4000; k++) begin
            logic w, r;
            int wi, ri, wc;
            string tag;
            w  = 1'($urandom % 2);
            r  = 1'($urandom % 3 != 0);
            wi = int'($urandom % 4);
            ri = int'($urandom % 4);
            wc = int'($urandom % 4);
            if (w && r && wi == ri) tag = "R7";
            else if (w && wc == 0) tag = "R6";
            else if (w && exp_cnt[wi] != 0) tag = "R4";
            else if (r && exp_cnt[ri] == 1) tag = "R5";
            else if (w && r) tag = "R9";
            else if (r) tag = "R3";
            else if (w) tag = "R2";
            else tag = "R8";
            step(w, wi, wc, r, ri, tag);
        end

        wr_req = 1'b0; rd_req = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule